// File: doc/BRIEF.md
# Ultrasound stimulation protocol sequencer

This block is the control state machine of a wirelessly powered nerve stimulator. The stimulator takes both power and commands from an ultrasound carrier. The sequencer watches two inputs. The first is a watchdog level that says the carrier has been absent for a few microseconds. The second is the rectified carrier clock. From these it steps the stimulator through its phases: ready, amplitude capture, setup, stimulation, interphase gap, and short/recharge. In each phase it raises the enables for the matching analog pieces: the time-to-code converter, the current reference, the DAC output, the reflection modulator and the output short.

A command is a carrier-free gap, then a carrier burst. The length of the gap sets the amplitude. The burst first lets the bias settle for a fixed number of carrier cycles and then stimulates. When the carrier drops again, the sequencer opens an interphase gap. The next burst shorts the electrode and recharges the store. An external safety timer may report that stimulation has overrun. In that case the sequencer jumps straight to short/recharge. This swaps the meaning of the following bursts, so the next burst after a carrier-free gap becomes a fresh stimulation and not a recharge.

All inputs are synchronous to `clk`. Edges on the watchdog and carrier inputs are found by comparing each input with its value from the previous clock.

Top module: `stim_seq`

## Requirements
- R1: While `rst_n` is low, `phase_o` is 0 (ready) and all five enables are low.
- R2: In ready (0) or short (5), a rising edge of `wd_absent` moves the sequencer to amplitude capture (code 1). In that phase only `conv_en` is high.
- R3: In amplitude capture, a rising edge of `car_clk` moves the sequencer to setup (code 2). In setup only `ref_en` is high.
- R4: Setup ends on exactly the SETUP_CLKS-th (default 17) rising carrier edge after the edge that entered it, and the sequencer then moves to stimulate (code 3). On every earlier edge it stays in setup.
- R5: In stimulate, `ref_en`, `dac_en` and `mod_en` are high, and `conv_en` and `short_en` are low.
- R6: In stimulate, a rising edge of `wd_absent` with `safety_to` low moves the sequencer to the interphase gap (code 4). In the gap all enables are low.
- R7: In the gap, a rising carrier edge moves the sequencer to short (code 5). In short only `short_en` is high.
- R8: In stimulate, `safety_to` high moves the sequencer to short (code 5). This holds even when a watchdog rising edge arrives in the same cycle.
- R9: After an overrun short, a rising edge of `wd_absent` starts amplitude capture. The next carrier burst is then setup followed by stimulation.
- R10: `safety_to` has no effect outside stimulate. Carrier edges have no effect in ready, stimulate and short.
- R11: `short_en` and `dac_en` are never high together, and at most one of `conv_en`, `dac_en`, `short_en` is high.
- R12: In setup, a rising edge of `wd_absent` moves the sequencer to the gap (code 4) without stimulating.
- R13: A `wd_absent` level that is already high when reset is released is not an edge and leaves the sequencer in ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| wd_absent | input | 1 | High while the carrier has been absent for the watchdog time |
| car_clk | input | 1 | Rectified carrier clock, sampled on `clk` |
| safety_to | input | 1 | Safety-timer overrun strobe |
| phase_o | output | 3 | Current phase code: 0 ready, 1 amplitude, 2 setup, 3 stimulate, 4 gap, 5 short |
| conv_en | output | 1 | Time-to-code converter enable |
| ref_en | output | 1 | Current-reference enable |
| dac_en | output | 1 | DAC output enable |
| mod_en | output | 1 | Reflection modulation enable |
| short_en | output | 1 | Electrode short / recharge |

## Verification
The state register alone picks the enables, so a wrong state shows at the ports in the cycle after the edge that caused it. It appears as a wrong `phase_o` code and a wrong enable set. An off-by-one in the setup count shows as `dac_en` rising one carrier edge early or late. A lost overrun shows as `dac_en` still high after a `safety_to` strobe, when `short_en` should be high. A wrong priority between the overrun and the watchdog shows as code 4 where code 5 was due.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;

  typedef enum logic [2:0] {
    PH_READY = 3'd0,
    PH_AMP   = 3'd1,
    PH_SETUP = 3'd2,
    PH_STIM  = 3'd3,
    PH_GAP   = 3'd4,
    PH_SHORT = 3'd5
  } phase_e;

  typedef struct packed {
    logic conv;
    logic ref_on;
    logic dac;
    logic mod;
    logic shrt;
  } drive_t;

  // Map a phase to the enables it drives.
  function automatic drive_t phase_drive(phase_e p);
    drive_t d;
    d = '0;
    d.conv   = (p == PH_AMP);
    d.ref_on = (p == PH_SETUP) || (p == PH_STIM);
    d.dac    = (p == PH_STIM);
    d.mod    = (p == PH_STIM);
    d.shrt   = (p == PH_SHORT);
    return d;
  endfunction

endpackage

// File: rtl/stim_edge.sv
module stim_edge #(
  parameter logic RESET_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_LVL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/stim_setup_cnt.sv
module stim_setup_cnt #(
  parameter int CLKS = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(CLKS + 1);
  localparam logic [W-1:0] LAST = W'(CLKS - 1);

  logic [W-1:0] cnt_q;

  function automatic logic is_last(logic [W-1:0] c);
    return c == LAST;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign done = tick & is_last(cnt_q);
endmodule

// File: rtl/stim_phase_fsm.sv
module stim_phase_fsm
  import stim_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wd_rise,
  input  logic   car_rise,
  input  logic   overrun,
  input  logic   setup_done,
  output phase_e phase
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_READY: if (wd_rise) state_d = PH_AMP;
      PH_AMP:   if (car_rise) state_d = PH_SETUP;
      PH_SETUP: begin
        if (wd_rise)         state_d = PH_GAP;
        else if (setup_done) state_d = PH_STIM;
      end
      PH_STIM: begin
        if (overrun)      state_d = PH_SHORT;
        else if (wd_rise) state_d = PH_GAP;
      end
      PH_GAP:   if (car_rise) state_d = PH_SHORT;
      PH_SHORT: if (wd_rise) state_d = PH_AMP;
      default:  state_d = PH_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_READY;
    else        state_q <= state_d;
  end

  assign phase = state_q;
endmodule

// File: rtl/stim_seq.sv
module stim_seq
  import stim_seq_pkg::*;
#(
  parameter int SETUP_CLKS = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_absent,
  input  logic       car_clk,
  input  logic       safety_to,
  output logic [2:0] phase_o,
  output logic       conv_en,
  output logic       ref_en,
  output logic       dac_en,
  output logic       mod_en,
  output logic       short_en
);
  logic   wd_rise;
  logic   car_rise;
  logic   setup_done;
  logic   setup_tick;
  logic   setup_clr;
  phase_e phase_q;
  drive_t drv;

  stim_edge #(.RESET_LVL(1'b1)) wd_edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(wd_absent), .rise(wd_rise)
  );

  stim_edge #(.RESET_LVL(1'b0)) car_edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(car_clk), .rise(car_rise)
  );

  assign setup_tick = car_rise & (phase_q == PH_SETUP);
  assign setup_clr  = (phase_q != PH_SETUP);

  stim_setup_cnt #(.CLKS(SETUP_CLKS)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(setup_clr), .tick(setup_tick), .done(setup_done)
  );

  stim_phase_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .wd_rise(wd_rise), .car_rise(car_rise),
    .overrun(safety_to), .setup_done(setup_done), .phase(phase_q)
  );

  assign drv      = phase_drive(phase_q);
  assign phase_o  = phase_q;
  assign conv_en  = drv.conv;
  assign ref_en   = drv.ref_on;
  assign dac_en   = drv.dac;
  assign mod_en   = drv.mod;
  assign short_en = drv.shrt;
endmodule

// File: rtl/stim_seq_chk.sv
module stim_seq_chk
  import stim_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase,
  input logic       wd_rise,
  input logic       car_rise,
  input logic       safety_to,
  input logic       conv_en,
  input logic       ref_en,
  input logic       dac_en,
  input logic       short_en
);
  AST_NO_SHORT_WITH_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_en && dac_en)); // R11

  AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_en, dac_en, short_en})); // R11

  AST_AMP_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && car_rise) |=> (phase == 3'd2)); // R3

  AST_OVERRUN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && safety_to) |=> (phase == 3'd5 && short_en)); // R8

  AST_STIM_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && wd_rise && !safety_to) |=> (phase == 3'd4 && !dac_en && !ref_en)); // R6

  AST_GAP_TO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && car_rise) |=> (phase == 3'd5)); // R7

  AST_SHORT_TO_AMP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd5 && wd_rise) |=> (phase == 3'd1 && conv_en)); // R9

  AST_STIM_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_en) |-> ($past(phase) == 3'd2)); // R4

  AST_DAC_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    dac_en |-> ref_en); // R5
endmodule

bind stim_seq stim_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase_o), .wd_rise(wd_rise),
  .car_rise(car_rise), .safety_to(safety_to), .conv_en(conv_en),
  .ref_en(ref_en), .dac_en(dac_en), .short_en(short_en)
);

// File: tb/stim_seq_tb_top.sv
module stim_seq_tb_top;
  localparam int NSET = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_absent = 1'b0;
  logic car_clk = 1'b0;
  logic safety_to = 1'b0;
  logic [2:0] phase_o;
  logic conv_en, ref_en, dac_en, mod_en, short_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] ph;
    string      req;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  stim_seq #(.SETUP_CLKS(NSET)) dut_i (
    .clk(clk), .rst_n(rst_n), .wd_absent(wd_absent), .car_clk(car_clk),
    .safety_to(safety_to), .phase_o(phase_o), .conv_en(conv_en),
    .ref_en(ref_en), .dac_en(dac_en), .mod_en(mod_en), .short_en(short_en)
  );

  // Enables expected for a phase code, packed {conv, ref, dac, mod, short}.
  function automatic logic [4:0] outs_for(logic [2:0] ph);
    case (ph)
      3'd1:    return 5'b10000;
      3'd2:    return 5'b01000;
      3'd3:    return 5'b01110;
      3'd5:    return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  // Monitor: at each falling edge, compare the ports against the queued expectations.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e = q.pop_front();
      got = {conv_en, ref_en, dac_en, mod_en, short_en};
      total++;
      if (phase_o !== e.ph || got !== outs_for(e.ph)) begin
        bad++;
        $display("FAIL %s: phase=%0d outs=%b expected phase=%0d outs=%b",
                 e.req, phase_o, got, e.ph, outs_for(e.ph));
      end
      total++;
      if (short_en && dac_en) begin
        bad++;
        $display("FAIL R11: short and dac both high, actual=11 expected not both");
      end
    end
  end

  task automatic expect_ph(input logic [2:0] ph, input string req);
    exp_t e;
    e.ph = ph;
    e.req = req;
    q.push_back(e);
  endtask

  // Driver: apply inputs at the falling edge, let one rising edge pass.
  task automatic step(input logic wd, input logic car, input logic to);
    @(negedge clk);
    wd_absent = wd;
    car_clk = car;
    safety_to = to;
    @(posedge clk);
    #1;
  endtask

  // Carrier pulse; the expectation is queued after the rising half.
  task automatic car_pulse(input logic [2:0] ph, input string req);
    step(1'b0, 1'b1, 1'b0);
    expect_ph(ph, req);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_setup(input string req);
    for (int i = 1; i <= NSET; i++) begin
      car_pulse((i == NSET) ? 3'd3 : 3'd2, req);
    end
  endtask

  initial begin
    wd_absent = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_ph(3'd0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd0, "R13");
    step(1'b0, 1'b0, 1'b0);
    car_pulse(3'd0, "R10");
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd1, "R2");
    step(1'b1, 1'b0, 1'b1);
    expect_ph(3'd1, "R10");
    car_pulse(3'd2, "R3");
    run_setup("R4");
    expect_ph(3'd3, "R5");
    car_pulse(3'd3, "R10");
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd4, "R6");
    step(1'b1, 1'b0, 1'b1);
    expect_ph(3'd4, "R10");
    car_pulse(3'd5, "R7");
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd1, "R2");
    car_pulse(3'd2, "R3");
    run_setup("R4");
    step(1'b1, 1'b0, 1'b1);
    expect_ph(3'd5, "R8");
    car_pulse(3'd5, "R10");
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd1, "R9");
    car_pulse(3'd2, "R9");
    run_setup("R9");
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd4, "R6");
    car_pulse(3'd5, "R7");
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd1, "R2");
    car_pulse(3'd2, "R3");
    for (int i = 0; i < 5; i++) car_pulse(3'd2, "R4");
    step(1'b1, 1'b0, 1'b0);
    expect_ph(3'd4, "R12");
    step(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule